// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block lets a clocked on-chip master read and write an external, byte-wide asynchronous static RAM of 524,288 words. The master presents one request at a time: an address, a read/write flag and write data. It holds the request until the controller acknowledges it. Read data comes back with a one-cycle valid strobe.

On the memory side the controller drives active-low chip select, write strobe and output enable, a 19-bit address, and the outgoing half of the 8-bit data bus with its own tristate enable. It takes the incoming half of the bus separately. Clock-cycle wait counts meet the memory's access and write-pulse timing, and these counts are compile-time parameters. The controller keeps the memory in standby whenever no access is running. It releases and claims the shared bus in an order that never lets both sides drive it at once.

A write holds the write strobe low for a set number of cycles. It then raises the strobe while address, data and chip select stay put, so the memory latches the byte on that rising edge. Only after that does the controller leave the bus.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, mem_ce_n, mem_we_n and mem_oe_n are 1, and mem_dq_oe, req_ack and rd_valid are 0.
- R2: mem_ce_n is 1 in every cycle in which no memory access is in progress, including the cycle in which req_ack is high.
- R3: A read holds mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 for exactly ACC_N cycles, beginning in the cycle after the accepting clock edge. req_ack is high at the ACC_N+1-th clock edge, counting the accepting edge as the first.
- R4: A write holds mem_ce_n=0, mem_oe_n=1 and mem_dq_oe=1 throughout. mem_we_n is 0 for exactly WR_N cycles, then 1 for one more cycle with chip select still low. After that chip select rises, the driver is released, and req_ack is seen at the WR_N+2-th edge.
- R5: mem_we_n and mem_oe_n are never both 0, and mem_dq_oe is 1 only while mem_oe_n is 1.
- R6: At the cycle in which mem_we_n rises, mem_ce_n is 0, mem_dq_oe is 1, and mem_addr and mem_dq_out hold the values of the previous cycle.
- R7: When a write follows a read, mem_oe_n is high for at least two cycles before mem_dq_oe turns on. The write is accepted TURN_N-1 cycles later than it would be after another write.
- R8: Only one request is in flight at a time. req_ack is a single-cycle pulse. A request still held high during the acknowledge cycle is not accepted again.
- R9: A wait count parameter set to 0 behaves as 1. With all counts at 0, a read is acknowledged at the second edge and a write at the third.
- R10: rd_valid is high only in the acknowledge cycle of a read, with rd_data equal to the word the memory drove. It stays 0 when a write is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Master request, held until req_ack |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Byte to write |
| req_ack | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | Read data valid, one cycle |
| rd_data | output | DATA_W | Captured read byte |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Tristate enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Byte read from the data bus |

## Verification
Two things can land in the same cycle. One is the acknowledge that ends an access. The other is a master request that is still asserted, either the same request held one cycle too long or a new write arriving while the bus is still turning around after a read. The bench provokes the first case by keeping req_valid high across the acknowledge cycle, then confirms that chip select stays high. It provokes the second by issuing a write directly after a read, and judges the result from the measured acknowledge latency and the output-enable history seen before the driver switches on.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_WHOLD = 2'd3
    } ctrl_state_e;

    function automatic int unsigned at_least_one(input int unsigned v);
        return (v < 1) ? 1 : v;
    endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              valid_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d       = cap_q;
        cap_d.valid = cap_i;
        if (cap_i) cap_d.data = din_i;
    end

    always_ff @(posedge clk) begin
        if (rst) cap_q <= '0;
        else     cap_q <= cap_d;
    end

    assign dout_o  = cap_q.data;
    assign valid_o = cap_q.valid;

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
    parameter int unsigned ADDR_W   = 19,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned ACC_CYC  = 2,
    parameter int unsigned WR_CYC   = 2,
    parameter int unsigned TURN_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ack,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    import sram_ctrl_pkg::*;

    localparam int unsigned ACC_N  = at_least_one(ACC_CYC);
    localparam int unsigned WR_N   = at_least_one(WR_CYC);
    localparam int unsigned TURN_N = at_least_one(TURN_CYC);
    localparam int unsigned MAX_AW = (ACC_N > WR_N) ? ACC_N : WR_N;
    localparam int unsigned MAX_N  = (MAX_AW > TURN_N) ? MAX_AW : TURN_N;
    localparam int unsigned CNT_W  = $clog2(MAX_N + 1);

    typedef struct packed {
        ctrl_state_e       st;
        logic              ce_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              ack;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic             wait_ld, turn_ld, cap_pulse;
    logic [CNT_W-1:0] wait_val, wait_cnt, turn_cnt;

    sram_wait_cnt #(.CNT_W(CNT_W)) u_wait (
        .clk        (clk),
        .rst        (rst),
        .load_i     (wait_ld),
        .load_val_i (wait_val),
        .cnt_o      (wait_cnt)
    );

    sram_wait_cnt #(.CNT_W(CNT_W)) u_turn (
        .clk        (clk),
        .rst        (rst),
        .load_i     (turn_ld),
        .load_val_i (CNT_W'(TURN_N)),
        .cnt_o      (turn_cnt)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .cap_i   (cap_pulse),
        .din_i   (mem_dq_in),
        .dout_o  (rd_data),
        .valid_o (rd_valid)
    );

    always_comb begin
        ctrl_d     = ctrl_q;
        ctrl_d.ack = 1'b0;
        wait_ld    = 1'b0;
        wait_val   = CNT_W'(ACC_N);
        turn_ld    = 1'b0;
        cap_pulse  = 1'b0;
        unique case (ctrl_q.st)
            ST_IDLE: begin
                // accept nothing in the acknowledge cycle; writes wait out turnaround
                if (req_valid && !ctrl_q.ack && (!req_write || turn_cnt == '0)) begin
                    ctrl_d.addr = req_addr;
                    ctrl_d.ce_n = 1'b0;
                    wait_ld     = 1'b1;
                    if (req_write) begin
                        ctrl_d.st    = ST_WRITE;
                        ctrl_d.we_n  = 1'b0;
                        ctrl_d.dq_oe = 1'b1;
                        ctrl_d.wdata = req_wdata;
                        wait_val     = CNT_W'(WR_N);
                    end else begin
                        ctrl_d.st   = ST_READ;
                        ctrl_d.oe_n = 1'b0;
                    end
                end
            end
            ST_READ: begin
                if (wait_cnt == CNT_W'(1)) begin
                    cap_pulse   = 1'b1;
                    turn_ld     = 1'b1;
                    ctrl_d.st   = ST_IDLE;
                    ctrl_d.ce_n = 1'b1;
                    ctrl_d.oe_n = 1'b1;
                    ctrl_d.ack  = 1'b1;
                end
            end
            ST_WRITE: begin
                if (wait_cnt == CNT_W'(1)) begin
                    ctrl_d.st   = ST_WHOLD;
                    ctrl_d.we_n = 1'b1;
                end
            end
            ST_WHOLD: begin
                ctrl_d.st    = ST_IDLE;
                ctrl_d.ce_n  = 1'b1;
                ctrl_d.dq_oe = 1'b0;
                ctrl_d.ack   = 1'b1;
            end
            default: ctrl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q       <= '0;
            ctrl_q.st    <= ST_IDLE;
            ctrl_q.ce_n  <= 1'b1;
            ctrl_q.we_n  <= 1'b1;
            ctrl_q.oe_n  <= 1'b1;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign req_ack    = ctrl_q.ack;
    assign mem_ce_n   = ctrl_q.ce_n;
    assign mem_we_n   = ctrl_q.we_n;
    assign mem_oe_n   = ctrl_q.oe_n;
    assign mem_addr   = ctrl_q.addr;
    assign mem_dq_out = ctrl_q.wdata;
    assign mem_dq_oe  = ctrl_q.dq_oe;

    a_r2_standby_at_ack: assert property (@(posedge clk) disable iff (rst)
        req_ack |-> mem_ce_n);

    a_r4_strobe_needs_select: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce_n && mem_dq_oe));

    a_r5_no_we_oe_overlap: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n);

    a_r5_drive_when_disabled: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);

    a_r6_stable_at_strobe_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_out)));

    a_r7_turnaround_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> ($past(mem_oe_n) && $past(mem_oe_n, 2)));

    a_r8_ack_single: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> !req_ack);

    a_r10_valid_with_ack: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> req_ack);

endmodule

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;

    localparam int ACC_T = 2, WR_T = 2, TURN_T = 2;
    localparam int ACC_E = (ACC_T < 1) ? 1 : ACC_T;
    localparam int WR_E  = (WR_T < 1) ? 1 : WR_T;
    localparam int TRN_E = (TURN_T < 1) ? 1 : TURN_T;

    // {write, addr[18:0], data[7:0]}
    localparam logic [27:0] VEC [0:9] = '{
        {1'b1, 19'h00011, 8'hA5},
        {1'b1, 19'h7FFFF, 8'h3C},
        {1'b0, 19'h00011, 8'h00},
        {1'b0, 19'h7FFFF, 8'h00},
        {1'b1, 19'h00100, 8'h00},
        {1'b1, 19'h40022, 8'hFF},
        {1'b0, 19'h00100, 8'h00},
        {1'b0, 19'h40022, 8'h00},
        {1'b1, 19'h00011, 8'h5A},
        {1'b0, 19'h00011, 8'h00}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic req_ack, rd_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  rd_data, mem_dq_out, mem_dq_in;
    logic [18:0] mem_addr;

    logic r0_valid = 1'b0, r0_write = 1'b0;
    logic m_ack, m_rdv, m_ce_n, m_we_n, m_oe_n, m_dq_oe;
    logic [7:0]  m_rdata, m_dq_out, m_dq_in;
    logic [18:0] m_addr;

    logic [7:0] model_mem [0:255];
    logic [7:0] exp_mem   [0:255];
    int n_tests = 0, n_fail = 0;
    bit prev_read = 1'b0;

    always #2.5 clk = ~clk;

    sram_async_ctrl #(.ACC_CYC(ACC_T), .WR_CYC(WR_T), .TURN_CYC(TURN_T)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

    sram_async_ctrl #(.ACC_CYC(0), .WR_CYC(0), .TURN_CYC(0)) dut_min (
        .clk(clk), .rst(rst), .req_valid(r0_valid), .req_write(r0_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(m_ack),
        .rd_valid(m_rdv), .rd_data(m_rdata), .mem_ce_n(m_ce_n),
        .mem_we_n(m_we_n), .mem_oe_n(m_oe_n), .mem_addr(m_addr),
        .mem_dq_out(m_dq_out), .mem_dq_oe(m_dq_oe), .mem_dq_in(m_dq_in));

    // memory model: drives only in read mode, latches on write-strobe rise
    assign mem_dq_in = (!mem_ce_n && mem_we_n && !mem_oe_n) ? model_mem[mem_addr[7:0]] : 8'hEE;
    assign m_dq_in   = (!m_ce_n && m_we_n && !m_oe_n) ? (m_addr[7:0] ^ 8'h5A) : 8'hEE;

    always @(posedge mem_we_n) begin
        if (!mem_ce_n) model_mem[mem_addr[7:0]] <= mem_dq_oe ? mem_dq_out : 8'hEE;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_op(input bit w, input logic [18:0] a, input logic [7:0] d, input bit hold);
        int lat = 0, ce_lo = 0, we_lo = 0, oe_lo = 0, clash = 0, exp_lat;
        bit got = 1'b0;
        exp_lat = w ? (WR_E + 2 + ((prev_read && TRN_E > 1) ? TRN_E - 1 : 0)) : (ACC_E + 1);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        while (!got && lat < 60) begin
            @(posedge clk); lat++;
            @(negedge clk);
            if (!mem_ce_n) ce_lo++;
            if (!mem_we_n) we_lo++;
            if (!mem_oe_n) oe_lo++;
            if ((mem_dq_oe && !mem_oe_n) || (!mem_we_n && !mem_oe_n)) clash++;
            if (req_ack) got = 1'b1;
        end
        if (w) chk(lat == exp_lat, "R4/R7 write ack latency", lat, exp_lat);
        else   chk(lat == exp_lat, "R3 read ack latency", lat, exp_lat);
        chk(clash == 0, "R5 pin mode exclusivity", clash, 0);
        chk(mem_ce_n == 1'b1, "R2 standby in ack cycle", mem_ce_n, 1);
        if (w) begin
            chk(we_lo == WR_E, "R4 write strobe width", we_lo, WR_E);
            chk(ce_lo == WR_E + 1, "R4 select spans strobe and hold", ce_lo, WR_E + 1);
            chk(oe_lo == 0, "R4 output enable high in write", oe_lo, 0);
            chk(rd_valid == 1'b0, "R10 no valid on write", rd_valid, 0);
            exp_mem[a[7:0]] = d;
        end else begin
            chk(oe_lo == ACC_E && ce_lo == ACC_E && we_lo == 0, "R3 read pin window", oe_lo, ACC_E);
            chk(rd_valid == 1'b1, "R10 valid on read ack", rd_valid, 1);
            chk(rd_data == exp_mem[a[7:0]], "R10 read data", rd_data, exp_mem[a[7:0]]);
        end
        if (hold) @(negedge clk);
        req_valid = 1'b0;
        prev_read = !w;
    endtask

    task automatic op_min(input bit w, input logic [18:0] a, input int exp_lat);
        int lat = 0;
        bit got = 1'b0;
        @(negedge clk);
        r0_valid = 1'b1; r0_write = w; req_addr = a; req_wdata = 8'h77;
        while (!got && lat < 60) begin
            @(posedge clk); lat++;
            @(negedge clk);
            if (m_ack) got = 1'b1;
        end
        chk(lat == exp_lat, "R9 zero count clamps to one", lat, exp_lat);
        if (!w) chk(m_rdv && m_rdata == (a[7:0] ^ 8'h5A), "R9 R10 read data at minimum counts",
                    m_rdata, a[7:0] ^ 8'h5A);
        r0_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state during reset
        chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !req_ack && !rd_valid,
            "R1 reset pin state", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !req_ack,
            "R1 after reset release", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);

        for (int i = 0; i < 10; i++) begin
            do_op(VEC[i][27], VEC[i][26:8], VEC[i][7:0], 1'b0);
        end

        // R8: request held through the acknowledge cycle is not taken again
        do_op(1'b0, 19'h00011, 8'h00, 1'b1);
        begin
            int ce_seen = 0;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                if (!mem_ce_n) ce_seen++;
            end
            chk(ce_seen == 0, "R8 no re-accept of held request", ce_seen, 0);
            chk(ce_seen == 0 && !mem_dq_oe, "R2 standby while idle", ce_seen, 0);
        end

        // R7: read immediately followed by a write
        do_op(1'b0, 19'h7FFFF, 8'h00, 1'b0);
        do_op(1'b1, 19'h00033, 8'hC3, 1'b0);
        do_op(1'b0, 19'h00033, 8'h00, 1'b0);

        // R9: instance with all wait counts at zero
        op_min(1'b1, 19'h00033, 3);
        op_min(1'b0, 19'h00033, 2);

        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule